// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block is the tag and state store of a set-associative cache. For every way of every set it keeps a line-address tag, a two-bit access permission and a true-LRU rank. A cache controller sends it one command per cycle: an access check, a presence test, an availability test, allocate, deallocate, a victim probe, or a permission update. One cycle later it returns a response with the hit flag, the way concerned, the victim line address, the availability flag and an error flag. Data storage, coherence actions and byte access belong to other blocks.

A line takes part in tag matching only while its permission is not the absent state. An absent way is a free way, so a free way is simply a way with absent permission. A new line starts out invalid, and the controller raises its permission once the fill completes. A command whose precondition does not hold is refused: the error flag is raised and no state changes.

Top module: `tag_directory`

## Requirements
- R1: A command presented with `cmd_valid` high at a rising edge gets its response in the next cycle, with `rsp_valid` high. In a cycle that follows no command, `rsp_valid` is low.
- R2: The set index is `addr[OFFSET_W +: SET_W]`, where SET_W = log2(SETS). The stored tag is the bits above the set index. Lines in different sets never interact.
- R3: After reset every way has absent permission. Presence tests miss, and a probe of any set is refused.
- R4: Command codes are 0 none, 1 access, 2 presence, 3 availability, 4 allocate, 5 deallocate, 6 probe, 7 set permission. Permission codes are 0 absent, 1 invalid, 2 read-only, 3 read-write. Request kinds are 0 load, 1 instruction fetch, 2 store. An access sets `rsp_hit` when the matching line is read-write, or when it is read-only and the kind is load or fetch. A store to a read-only line fails, and any access to an invalid line fails.
- R5: `rsp_way` is the matched way for access, presence, deallocate and set permission. It is the chosen way for allocate and probe. It is 0 on a miss, on an error, and for the other commands.
- R6: An access whose tag matches makes that way the most recently used in its set, even when permission denies the access.
- R7: Allocate puts the tag into the lowest-numbered absent way, sets that way to invalid and makes it most recently used. It is refused when the tag is already present or when no way is absent.
- R8: `rsp_avail` is high when the address is present in its set or when the set has an absent way. It is reported for every command.
- R9: A probe of a set with no absent way returns the least recently used way in `rsp_way` and its line address, with zero offset bits, in `rsp_victim`. A probe is refused when an absent way exists. `rsp_victim` is 0 in every other response.
- R10: Deallocate sets the matching way to absent, so a later allocate can reuse it. It is refused on a miss.
- R11: Set permission writes `perm_in` to the matching way. Writing absent frees the way. It is refused on a miss.
- R12: A refused command raises `rsp_err` and changes no tag, permission or LRU state.
- R13: A presence test reports a match in `rsp_hit` and leaves the LRU order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd | input | 3 | Command code |
| addr | input | ADDR_W | Line-aligned request address |
| req_kind | input | 2 | Request kind for an access check |
| perm_in | input | 2 | New permission for set permission |
| rsp_valid | output | 1 | Response is present |
| rsp_hit | output | 1 | Access granted, or presence matched |
| rsp_way | output | log2(WAYS) | Way concerned by the response |
| rsp_avail | output | 1 | Address is present or the set has a free way |
| rsp_err | output | 1 | Command refused |
| rsp_victim | output | ADDR_W | Victim line address for a probe |

## Verification
The hardest condition to reach from the ports is a full set whose LRU order differs from the order in which its ways were filled. Only that condition shows whether permission-denied accesses and presence tests change the ranking as they should, and the probe works only when the set is full. Directed sequences fill one set and then deny a store to a read-only line. The random phase confines addresses to two sets and six tags, so sets fill, empty and reorder often, and a bench model predicts every response.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ACCESS  = 3'd1,
        OP_PRESENT = 3'd2,
        OP_AVAIL   = 3'd3,
        OP_ALLOC   = 3'd4,
        OP_FREE    = 3'd5,
        OP_PROBE   = 3'd6,
        OP_SETPERM = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PERM_ABSENT  = 2'd0,
        PERM_INVALID = 2'd1,
        PERM_RDONLY  = 2'd2,
        PERM_RDWR    = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_FETCH = 2'd1,
        REQ_STORE = 2'd2,
        REQ_RSVD  = 2'd3
    } req_e;

endpackage

// File: rtl/tdir_way_search.sv
module tdir_way_search #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0][1:0]       set_perms,
    input  logic [WAYS-1:0][WAY_W-1:0] set_ranks,
    input  logic [TAG_W-1:0]           req_tag,
    output logic [WAYS-1:0]            match_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic [1:0]                 hit_perm,
    output logic                       free_any,
    output logic [WAY_W-1:0]           free_way,
    output logic [WAY_W-1:0]           victim_way
);
    import tdir_pkg::*;

    logic [WAYS-1:0] free_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign free_vec[w]  = (set_perms[w] == PERM_ABSENT);
        assign match_vec[w] = !free_vec[w] && (set_tags[w] == req_tag);
    end

    always_comb begin
        hit_way    = '0;
        free_way   = '0;
        victim_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) hit_way  = WAY_W'(w);
            if (free_vec[w])  free_way = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (set_ranks[w] == '0) victim_way = WAY_W'(w);
        end
    end

    assign hit      = |match_vec;
    assign free_any = |free_vec;
    assign hit_perm = set_perms[hit_way];

endmodule

// File: rtl/tdir_lru_touch.sv
module tdir_lru_touch #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ranks,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAYS-1:0][WAY_W-1:0] ranks_next
);
    localparam logic [WAY_W-1:0] TOP_RANK = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] touched_rank;
    assign touched_rank = ranks[touch_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_rank
        always_comb begin
            if (WAY_W'(w) == touch_way) begin
                ranks_next[w] = TOP_RANK;
            end else if (ranks[w] > touched_rank) begin
                ranks_next[w] = ranks[w] - 1'b1;
            end else begin
                ranks_next[w] = ranks[w];
            end
        end
    end

endmodule

// File: rtl/tag_directory.sv
module tag_directory #(
    parameter int ADDR_W   = 16,
    parameter int OFFSET_W = 4,
    parameter int SETS     = 4,
    parameter int WAYS     = 4,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        perm_in,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_avail,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_victim
);
    import tdir_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFFSET_W - SET_W;

    typedef struct {
        logic [TAG_W-1:0]  tag  [SETS][WAYS];
        logic [1:0]        perm [SETS][WAYS];
        logic [WAY_W-1:0]  rank [SETS][WAYS];
        logic              r_valid;
        logic              r_hit;
        logic              r_avail;
        logic              r_err;
        logic [WAY_W-1:0]  r_way;
        logic [ADDR_W-1:0] r_victim;
    } state_t;

    state_t st_d, st_q;

    op_e              op;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] req_tag;

    assign op      = op_e'(cmd);
    assign set_idx = addr[OFFSET_W +: SET_W];
    assign req_tag = addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0][TAG_W-1:0] cur_tags;
    logic [WAYS-1:0][1:0]       cur_perms;
    logic [WAYS-1:0][WAY_W-1:0] cur_ranks;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            cur_tags[w]  = st_q.tag[set_idx][w];
            cur_perms[w] = st_q.perm[set_idx][w];
            cur_ranks[w] = st_q.rank[set_idx][w];
        end
    end

    logic [WAYS-1:0]  match_vec;
    logic             lk_hit;
    logic [WAY_W-1:0] hit_way;
    logic [1:0]       hit_perm;
    logic             free_any;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] victim_way;

    tdir_way_search #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_search (
        .set_tags   (cur_tags),
        .set_perms  (cur_perms),
        .set_ranks  (cur_ranks),
        .req_tag    (req_tag),
        .match_vec  (match_vec),
        .hit        (lk_hit),
        .hit_way    (hit_way),
        .hit_perm   (hit_perm),
        .free_any   (free_any),
        .free_way   (free_way),
        .victim_way (victim_way)
    );

    logic [WAY_W-1:0]           touch_way;
    logic [WAYS-1:0][WAY_W-1:0] touched_ranks;

    assign touch_way = (op == OP_ALLOC) ? free_way : hit_way;

    tdir_lru_touch #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
        .ranks      (cur_ranks),
        .touch_way  (touch_way),
        .ranks_next (touched_ranks)
    );

    logic read_kind;
    assign read_kind = (req_e'(req_kind) == REQ_LOAD) || (req_e'(req_kind) == REQ_FETCH);

    always_comb begin
        st_d          = st_q;
        st_d.r_valid  = cmd_valid;
        st_d.r_hit    = 1'b0;
        st_d.r_avail  = 1'b0;
        st_d.r_err    = 1'b0;
        st_d.r_way    = '0;
        st_d.r_victim = '0;
        if (cmd_valid) begin
            st_d.r_avail = lk_hit || free_any;
            case (op)
                OP_ACCESS: begin
                    if (lk_hit) begin
                        st_d.r_way = hit_way;
                        st_d.r_hit = (hit_perm == PERM_RDWR) ||
                                     ((hit_perm == PERM_RDONLY) && read_kind);
                        for (int w = 0; w < WAYS; w++) st_d.rank[set_idx][w] = touched_ranks[w];
                    end
                end
                OP_PRESENT: begin
                    st_d.r_hit = lk_hit;
                    if (lk_hit) st_d.r_way = hit_way;
                end
                OP_ALLOC: begin
                    if (lk_hit || !free_any) begin
                        st_d.r_err = 1'b1;
                    end else begin
                        st_d.r_way                    = free_way;
                        st_d.tag[set_idx][free_way]  = req_tag;
                        st_d.perm[set_idx][free_way] = PERM_INVALID;
                        for (int w = 0; w < WAYS; w++) st_d.rank[set_idx][w] = touched_ranks[w];
                    end
                end
                OP_FREE: begin
                    if (!lk_hit) begin
                        st_d.r_err = 1'b1;
                    end else begin
                        st_d.r_way                   = hit_way;
                        st_d.perm[set_idx][hit_way] = PERM_ABSENT;
                    end
                end
                OP_PROBE: begin
                    if (free_any) begin
                        st_d.r_err = 1'b1;
                    end else begin
                        st_d.r_way    = victim_way;
                        st_d.r_victim = {cur_tags[victim_way], set_idx, {OFFSET_W{1'b0}}};
                    end
                end
                OP_SETPERM: begin
                    if (!lk_hit) begin
                        st_d.r_err = 1'b1;
                    end else begin
                        st_d.r_way                   = hit_way;
                        st_d.perm[set_idx][hit_way] = perm_in;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q.tag[s][w]  <= '0;
                    st_q.perm[s][w] <= PERM_ABSENT;
                    st_q.rank[s][w] <= WAY_W'(w);
                end
            end
            st_q.r_valid  <= 1'b0;
            st_q.r_hit    <= 1'b0;
            st_q.r_avail  <= 1'b0;
            st_q.r_err    <= 1'b0;
            st_q.r_way    <= '0;
            st_q.r_victim <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.r_valid;
    assign rsp_hit    = st_q.r_hit;
    assign rsp_way    = st_q.r_way;
    assign rsp_avail  = st_q.r_avail;
    assign rsp_err    = st_q.r_err;
    assign rsp_victim = st_q.r_victim;

endmodule

// File: rtl/tdir_checker.sv
module tdir_checker #(
    parameter int WAYS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [2:0]      cmd,
    input logic [1:0]      req_kind,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_err,
    input logic [WAYS-1:0] match_vec,
    input logic            lk_hit,
    input logic [1:0]      hit_perm,
    input logic            free_any
);
    import tdir_pkg::*;

    // R1: a command yields a response in the following cycle
    assert_rsp_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    // R1: no response without a command
    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R7: duplicate allocation is refused, so at most one way matches
    assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R4: a store to a read-only line is denied
    assert_store_ro_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == OP_ACCESS && lk_hit && hit_perm == PERM_RDONLY &&
         req_kind == REQ_STORE) |=> !rsp_hit);

    // R4: a read-write line grants every access
    assert_rdwr_grants_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == OP_ACCESS && lk_hit && hit_perm == PERM_RDWR) |=> rsp_hit);

    // R9: a probe is refused while a free way exists
    assert_probe_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == OP_PROBE && free_any) |=> rsp_err);

    // R7: a legal allocation is accepted
    assert_alloc_accepted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == OP_ALLOC && !lk_hit && free_any) |=> !rsp_err);

endmodule

bind tag_directory tdir_checker #(.WAYS(WAYS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_err   (rsp_err),
    .match_vec (match_vec),
    .lk_hit    (lk_hit),
    .hit_perm  (hit_perm),
    .free_any  (free_any)
);

// File: tb/test_tag_directory.sv
`timescale 1ns/1ps
module test_tag_directory;
    localparam int ADDR_W   = 16;
    localparam int OFFSET_W = 4;
    localparam int SETS     = 4;
    localparam int WAYS     = 4;
    localparam int WAY_W    = $clog2(WAYS);
    localparam int SET_W    = $clog2(SETS);
    localparam int TAG_W    = ADDR_W - OFFSET_W - SET_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0]        req_kind = '0;
    logic [1:0]        perm_in = '0;
    logic              rsp_valid, rsp_hit, rsp_avail, rsp_err;
    logic [WAY_W-1:0]  rsp_way;
    logic [ADDR_W-1:0] rsp_victim;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tag_directory #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .WAYS(WAYS)) i_tag_directory (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .addr(addr),
        .req_kind(req_kind), .perm_in(perm_in), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_way(rsp_way), .rsp_avail(rsp_avail), .rsp_err(rsp_err), .rsp_victim(rsp_victim)
    );

    // reference model
    logic [TAG_W-1:0] m_tag [SETS][WAYS];
    int               m_perm [SETS][WAYS];
    int               m_rank [SETS][WAYS];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int st);
        return {TAG_W'(tg), SET_W'(st), {OFFSET_W{1'b0}}};
    endfunction

    task automatic mtouch(input int s, input int t);
        int tr = m_rank[s][t];
        for (int w = 0; w < WAYS; w++) if (m_rank[s][w] > tr) m_rank[s][w]--;
        m_rank[s][t] = WAYS - 1;
    endtask

    task automatic run(input int op, input logic [ADDR_W-1:0] a, input int rk, input int pm);
        int s = int'(a[OFFSET_W +: SET_W]);
        logic [TAG_W-1:0] t = a[ADDR_W-1 -: TAG_W];
        int mw = -1, fw = -1, vw = 0;
        logic e_hit = 0, e_err = 0, e_av;
        int e_way = 0;
        logic [ADDR_W-1:0] e_vic = '0;
        string r;
        for (int w = 0; w < WAYS; w++) begin
            if (m_perm[s][w] != 0 && m_tag[s][w] == t && mw < 0) mw = w;
            if (m_perm[s][w] == 0 && fw < 0) fw = w;
            if (m_rank[s][w] == 0) vw = w;
        end
        e_av = (mw >= 0) || (fw >= 0);
        case (op)
            1: begin r = "R4";
                if (mw >= 0) begin
                    e_way = mw;
                    e_hit = (m_perm[s][mw] == 3) || (m_perm[s][mw] == 2 && rk != 2);
                    mtouch(s, mw);
                end end
            2: begin r = "R13"; e_hit = (mw >= 0); if (mw >= 0) e_way = mw; end
            3: r = "R8";
            4: begin r = "R7";
                if (mw >= 0 || fw < 0) begin e_err = 1; r = "R12"; end
                else begin e_way = fw; m_tag[s][fw] = t; m_perm[s][fw] = 1; mtouch(s, fw); end end
            5: begin r = "R10";
                if (mw < 0) begin e_err = 1; r = "R12"; end
                else begin e_way = mw; m_perm[s][mw] = 0; end end
            6: begin r = "R9";
                if (fw >= 0) e_err = 1;
                else begin e_way = vw; e_vic = {m_tag[s][vw], SET_W'(s), {OFFSET_W{1'b0}}}; end end
            7: begin r = "R11";
                if (mw < 0) begin e_err = 1; r = "R12"; end
                else begin e_way = mw; m_perm[s][mw] = pm; end end
            default: r = "R1";
        endcase
        @(negedge clk);
        chk("R1", "idle rsp_valid", 32'(rsp_valid), 32'd0);
        cmd_valid = 1'b1; cmd = 3'(op); addr = a; req_kind = 2'(rk); perm_in = 2'(pm);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(r, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk("R5", "rsp_way", 32'(rsp_way), 32'(e_way));
        chk("R8", "rsp_avail", 32'(rsp_avail), 32'(e_av));
        chk(r, "rsp_err", 32'(rsp_err), 32'(e_err));
        chk("R9", "rsp_victim", 32'(rsp_victim), 32'(e_vic));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = '0; m_perm[s][w] = 0; m_rank[s][w] = w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: empty after reset
        run(2, mk(1, 0), 0, 0);
        run(2, mk(0, 3), 0, 0);
        run(6, mk(1, 0), 0, 0);
        // R7: fill set 0 in way order
        for (int i = 1; i <= WAYS; i++) run(4, mk(i, 0), 0, 0);
        run(6, mk(9, 0), 0, 0);
        // R2: same tag in another set is independent
        run(2, mk(1, 1), 0, 0);
        run(4, mk(1, 1), 0, 0);
        run(2, mk(1, 0), 0, 0);
        // R4: invalid line fails; read-only store denied but touches (R6)
        run(1, mk(1, 0), 0, 0);
        run(7, mk(1, 0), 0, 2);
        run(1, mk(2, 0), 2, 0);
        run(1, mk(1, 0), 2, 0);
        run(6, mk(5, 0), 0, 0);
        run(1, mk(3, 0), 1, 0);
        run(7, mk(3, 0), 0, 3);
        run(1, mk(3, 0), 2, 0);
        // R13: presence leaves LRU alone
        run(2, mk(4, 0), 0, 0);
        run(6, mk(5, 0), 0, 0);
        // R12: refused commands
        run(4, mk(2, 0), 0, 0);
        run(4, mk(7, 0), 0, 0);
        run(5, mk(7, 0), 0, 0);
        run(7, mk(7, 0), 0, 3);
        run(6, mk(7, 0), 0, 0);
        // R10: free way reused at lowest index
        run(5, mk(3, 0), 0, 0);
        run(3, mk(7, 0), 0, 0);
        run(4, mk(7, 0), 0, 0);
        // R11: writing absent frees a way
        run(7, mk(1, 0), 0, 0);
        run(2, mk(1, 0), 0, 0);
        run(4, mk(8, 0), 0, 0);
        run(0, mk(0, 0), 0, 0);
        // random phase over two sets and six tags
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            int op;
            case (sel)
                0, 1: op = 4;
                2, 3: op = 1;
                4: op = 2;
                5: op = 3;
                6: op = 5;
                7: op = 6;
                default: op = 7;
            endcase
            run(op, mk($urandom_range(0, 5), $urandom_range(0, 1)),
                $urandom_range(0, 2), $urandom_range(0, 3));
        end
        finish_run();
    end
endmodule